// File: doc/BRIEF.md
# Shared-Pin Command and Data Link

This block carries DRAM commands and burst data between an accelerator-side controller and a memory-side endpoint over one 8-bit pin group. The pins are time-shared. Some cycles carry a command head byte, some carry a column byte, and the rest carry data beats. Only one side drives the pins in any cycle. A client hands in one request at a time through a valid/ready handshake: activate, precharge, read or write. Each request carries a bank, a row, a column and a 64-bit write burst.

The transmitter frames each request on the pins. Activate and precharge take one cycle each. Read and write take two. A write burst follows its column byte at once. A read leaves the pins undriven for one turnaround cycle, waits a fixed latency, and then takes eight beats back from the endpoint. The transmitter assembles those beats into one word. The endpoint decodes the stream, tracks the open row of each bank, and holds a small burst store indexed by bank, open row and the low column bits.

Top module: `shared_pin_link`

## Requirements
- R1: After reset, `req_ready` is 1, `rd_valid` is 0, and neither `link_host_drv` nor `link_dev_drv` is set.
- R2: An accepted activate drives exactly one link cycle, in the cycle after acceptance. That cycle carries the head byte {2'b00, bank[1:0], row[3:0]}, and `req_ready` stays 1 in that cycle, so activates can go back to back.
- R3: An accepted precharge drives exactly one link cycle carrying the head byte {2'b01, bank[1:0], 4'b0000}, and `req_ready` stays 1 in that cycle.
- R4: An accepted read or write drives two command cycles. The first carries the head byte {op, bank[1:0], 4'b0000}, where op is 2'b10 for a read and 2'b11 for a write. The second carries the 8-bit column.
- R5: A write drives its eight data beats in the eight cycles right after the column byte. Beat i is `req_wdata[8*i+7:8*i]`, and nothing else is driven.
- R6: After a read's column byte, the link is undriven for one turnaround cycle and then for RD_LAT more cycles. After that, the endpoint drives eight beats.
- R7: In the cycle after the last read beat, `rd_valid` is 1 for exactly one cycle and `req_ready` is 1. `rd_data` holds beat i in bits [8*i+7:8*i].
- R8: `req_ready` is 0 from the cycle after a read or write is accepted until its burst ends. A request presented while `req_ready` is 0 is ignored and changes nothing.
- R9: A read returns the burst last written to the same bank, the same low two column bits, and the row that the latest activate opened in that bank.
- R10: The controller and the endpoint never drive the link in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Transmitter can take a request |
| req_op | input | 2 | 00 activate, 01 precharge, 10 read, 11 write |
| req_bank | input | BANK_W | Bank |
| req_row | input | ROW_W | Row (activate only) |
| req_col | input | 8 | Column |
| req_wdata | input | BEATS*8 | Write burst, beat 0 in the low byte |
| rd_valid | output | 1 | One-cycle read completion pulse |
| rd_data | output | BEATS*8 | Assembled read burst |
| link_bus | output | 8 | Value on the shared pins |
| link_host_drv | output | 1 | Controller drives the pins |
| link_dev_drv | output | 1 | Endpoint drives the pins |

## Verification
The transmitter state and the endpoint's decode state must stay in step. Suppose one of them miscounts a command length, the bubble, the latency or a beat index. Then the next read shows it on the pins: a data beat lands one cycle early or late, or both sides drive the pins at once, or `rd_valid` lands off its cycle. Each of these shows within one burst of the error. A wrong open-row entry or a wrong store index stays hidden until a later read of that location. At that point `rd_data` and the returned beats differ from the scoreboard.

// File: rtl/slink_pkg.sv
package slink_pkg;

    localparam int LINK_W = 8;

    typedef enum logic [1:0] {
        OP_ACT = 2'b00,
        OP_PRE = 2'b01,
        OP_RD  = 2'b10,
        OP_WR  = 2'b11
    } slink_op_e;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_COL,
        TX_WDATA,
        TX_TURN,
        TX_RWAIT,
        TX_RDATA
    } tx_state_e;

    typedef enum logic [2:0] {
        EP_IDLE,
        EP_COL,
        EP_WDATA,
        EP_RWAIT,
        EP_RDATA
    } ep_state_e;

endpackage

// File: rtl/slink_tx.sv
module slink_tx
    import slink_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 4,
    parameter int BEATS  = 8,
    parameter int RD_LAT = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [1:0]                req_op,
    input  logic [BANK_W-1:0]         req_bank,
    input  logic [ROW_W-1:0]          req_row,
    input  logic [LINK_W-1:0]         req_col,
    input  logic [BEATS*LINK_W-1:0]   req_wdata,
    input  logic [LINK_W-1:0]         link_in,
    output logic [LINK_W-1:0]         tx_bus,
    output logic                      tx_drv,
    output logic                      rd_valid,
    output logic [BEATS*LINK_W-1:0]   rd_data
);
    localparam int DATA_W = BEATS * LINK_W;
    localparam int BEAT_W = $clog2(BEATS + 1);
    localparam int WAIT_W = (RD_LAT > 0) ? $clog2(RD_LAT + 1) : 1;
    localparam int ADDR_W = LINK_W - 2;

    typedef struct packed {
        tx_state_e           state;
        logic                wr;
        logic [LINK_W-1:0]   col;
        logic [DATA_W-1:0]   wbuf;
        logic [DATA_W-1:0]   rbuf;
        logic [BEAT_W-1:0]   beat;
        logic [WAIT_W-1:0]   wait_cnt;
        logic [LINK_W-1:0]   bus;
        logic                drv;
        logic                rd_valid;
    } tx_regs_t;

    tx_regs_t q, d;
    logic [ADDR_W-1:0] addr_field;

    always_comb begin
        if (req_op == OP_ACT) begin
            addr_field = ADDR_W'({req_bank, req_row});
        end else begin
            addr_field = ADDR_W'({req_bank, {ROW_W{1'b0}}});
        end
    end

    always_comb begin
        d          = q;
        d.rd_valid = 1'b0;
        case (q.state)
            TX_IDLE: begin
                d.drv = 1'b0;
                if (req_valid) begin
                    d.drv  = 1'b1;
                    d.bus  = {req_op, addr_field};
                    d.wr   = (req_op == OP_WR);
                    d.col  = req_col;
                    d.wbuf = req_wdata;
                    if (req_op == OP_RD || req_op == OP_WR) begin
                        d.state = TX_COL;
                    end
                end
            end
            TX_COL: begin
                d.drv  = 1'b1;
                d.bus  = q.col;
                d.beat = '0;
                d.state = q.wr ? TX_WDATA : TX_TURN;
            end
            TX_WDATA: begin
                if (q.beat == BEAT_W'(BEATS)) begin
                    d.drv   = 1'b0;
                    d.state = TX_IDLE;
                end else begin
                    d.drv  = 1'b1;
                    d.bus  = q.wbuf[int'(q.beat)*LINK_W +: LINK_W];
                    d.beat = q.beat + 1'b1;
                end
            end
            TX_TURN: begin
                d.drv      = 1'b0;
                d.wait_cnt = WAIT_W'(RD_LAT);
                d.state    = TX_RWAIT;
            end
            TX_RWAIT: begin
                if (q.wait_cnt == '0) begin
                    d.beat  = '0;
                    d.state = TX_RDATA;
                end else begin
                    d.wait_cnt = q.wait_cnt - 1'b1;
                end
            end
            TX_RDATA: begin
                d.rbuf[int'(q.beat)*LINK_W +: LINK_W] = link_in;
                if (q.beat == BEAT_W'(BEATS - 1)) begin
                    d.rd_valid = 1'b1;
                    d.state    = TX_IDLE;
                end else begin
                    d.beat = q.beat + 1'b1;
                end
            end
            default: d.state = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: TX_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.state == TX_IDLE);
    assign tx_bus    = q.bus;
    assign tx_drv    = q.drv;
    assign rd_valid  = q.rd_valid;
    assign rd_data   = q.rbuf;

endmodule

// File: rtl/slink_store.sv
module slink_store #(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 4,
    parameter int COL_IDX_W = 2,
    parameter int DATA_W    = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  act_en,
    input  logic [BANK_W-1:0]     act_bank,
    input  logic [ROW_W-1:0]      act_row,
    input  logic                  wr_en,
    input  logic [BANK_W-1:0]     wr_bank,
    input  logic [COL_IDX_W-1:0]  wr_col,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [BANK_W-1:0]     rd_bank,
    input  logic [COL_IDX_W-1:0]  rd_col,
    output logic [DATA_W-1:0]     rd_data
);
    localparam int NBANK  = 1 << BANK_W;
    localparam int IDX_W  = BANK_W + ROW_W + COL_IDX_W;
    localparam int DEPTH  = 1 << IDX_W;

    logic [ROW_W-1:0]  row_q [NBANK];
    logic [DATA_W-1:0] mem   [DEPTH];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [ROW_W-1:0] row_d;
        always_comb begin
            row_d = row_q[g];
            if (act_en && act_bank == BANK_W'(g)) begin
                row_d = act_row;
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q[g] <= '0;
            end else begin
                row_q[g] <= row_d;
            end
        end
    end

    logic [IDX_W-1:0] widx, ridx;
    assign widx = {wr_bank, row_q[wr_bank], wr_col};
    assign ridx = {rd_bank, row_q[rd_bank], rd_col};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[widx] <= wr_data;
        end
    end

    assign rd_data = mem[ridx];

endmodule

// File: rtl/slink_ep.sv
module slink_ep
    import slink_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 4,
    parameter int BEATS     = 8,
    parameter int RD_LAT    = 3,
    parameter int COL_IDX_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LINK_W-1:0]  link_in,
    input  logic               host_drv,
    output logic [LINK_W-1:0]  dev_bus,
    output logic               dev_drv
);
    localparam int DATA_W = BEATS * LINK_W;
    localparam int BEAT_W = $clog2(BEATS + 1);
    localparam int WAIT_W = (RD_LAT > 0) ? $clog2(RD_LAT + 1) : 1;

    typedef struct packed {
        ep_state_e              state;
        logic                   wr;
        logic [BANK_W-1:0]      bank;
        logic [COL_IDX_W-1:0]   col_idx;
        logic [DATA_W-1:0]      wbuf;
        logic [DATA_W-1:0]      rbuf;
        logic [BEAT_W-1:0]      beat;
        logic [WAIT_W-1:0]      wait_cnt;
        logic [LINK_W-1:0]      bus;
        logic                   drv;
    } ep_regs_t;

    ep_regs_t q, d;

    logic [1:0]           head_op;
    logic [BANK_W-1:0]    head_bank;
    logic [ROW_W-1:0]     head_row;
    logic                 act_en;
    logic                 wr_en;
    logic [DATA_W-1:0]    st_rdata;

    assign head_op   = link_in[LINK_W-1 -: 2];
    assign head_bank = link_in[ROW_W +: BANK_W];
    assign head_row  = link_in[ROW_W-1:0];

    always_comb begin
        d      = q;
        act_en = 1'b0;
        wr_en  = 1'b0;
        case (q.state)
            EP_IDLE: begin
                if (host_drv) begin
                    if (head_op == OP_ACT) begin
                        act_en = 1'b1;
                    end else if (head_op == OP_RD || head_op == OP_WR) begin
                        d.wr    = (head_op == OP_WR);
                        d.bank  = head_bank;
                        d.state = EP_COL;
                    end
                end
            end
            EP_COL: begin
                d.col_idx = link_in[COL_IDX_W-1:0];
                d.beat    = '0;
                if (q.wr) begin
                    d.state = EP_WDATA;
                end else begin
                    d.rbuf     = st_rdata;
                    d.wait_cnt = WAIT_W'(RD_LAT);
                    d.state    = EP_RWAIT;
                end
            end
            EP_WDATA: begin
                if (host_drv) begin
                    d.wbuf[int'(q.beat)*LINK_W +: LINK_W] = link_in;
                    if (q.beat == BEAT_W'(BEATS - 1)) begin
                        wr_en   = 1'b1;
                        d.state = EP_IDLE;
                    end else begin
                        d.beat = q.beat + 1'b1;
                    end
                end
            end
            EP_RWAIT: begin
                if (q.wait_cnt == '0) begin
                    d.drv   = 1'b1;
                    d.bus   = q.rbuf[LINK_W-1:0];
                    d.beat  = BEAT_W'(1);
                    d.state = EP_RDATA;
                end else begin
                    d.wait_cnt = q.wait_cnt - 1'b1;
                end
            end
            EP_RDATA: begin
                if (q.beat == BEAT_W'(BEATS)) begin
                    d.drv   = 1'b0;
                    d.state = EP_IDLE;
                end else begin
                    d.bus  = q.rbuf[int'(q.beat)*LINK_W +: LINK_W];
                    d.beat = q.beat + 1'b1;
                end
            end
            default: d.state = EP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{state: EP_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    slink_store #(
        .BANK_W    (BANK_W),
        .ROW_W     (ROW_W),
        .COL_IDX_W (COL_IDX_W),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_en   (act_en),
        .act_bank (head_bank),
        .act_row  (head_row),
        .wr_en    (wr_en),
        .wr_bank  (q.bank),
        .wr_col   (q.col_idx),
        .wr_data  (d.wbuf),
        .rd_bank  (q.bank),
        .rd_col   (link_in[COL_IDX_W-1:0]),
        .rd_data  (st_rdata)
    );

    assign dev_bus = q.bus;
    assign dev_drv = q.drv;

endmodule

// File: rtl/shared_pin_link.sv
module shared_pin_link
    import slink_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 4,
    parameter int BEATS     = 8,
    parameter int RD_LAT    = 3,
    parameter int COL_IDX_W = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [1:0]               req_op,
    input  logic [BANK_W-1:0]        req_bank,
    input  logic [ROW_W-1:0]         req_row,
    input  logic [7:0]               req_col,
    input  logic [BEATS*8-1:0]       req_wdata,
    output logic                     rd_valid,
    output logic [BEATS*8-1:0]       rd_data,
    output logic [7:0]               link_bus,
    output logic                     link_host_drv,
    output logic                     link_dev_drv
);
    logic [LINK_W-1:0] host_bus, dev_bus;

    slink_tx #(
        .BANK_W (BANK_W),
        .ROW_W  (ROW_W),
        .BEATS  (BEATS),
        .RD_LAT (RD_LAT)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .req_col   (req_col),
        .req_wdata (req_wdata),
        .link_in   (link_bus),
        .tx_bus    (host_bus),
        .tx_drv    (link_host_drv),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    slink_ep #(
        .BANK_W    (BANK_W),
        .ROW_W     (ROW_W),
        .BEATS     (BEATS),
        .RD_LAT    (RD_LAT),
        .COL_IDX_W (COL_IDX_W)
    ) u_ep (
        .clk      (clk),
        .rst_n    (rst_n),
        .link_in  (link_bus),
        .host_drv (link_host_drv),
        .dev_bus  (dev_bus),
        .dev_drv  (link_dev_drv)
    );

    always_comb begin
        if (link_host_drv) begin
            link_bus = host_bus;
        end else if (link_dev_drv) begin
            link_bus = dev_bus;
        end else begin
            link_bus = '0;
        end
    end

endmodule

// File: rtl/slink_chk.sv
module slink_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_op,
    input logic       rd_valid,
    input logic [7:0] link_bus,
    input logic       link_host_drv,
    input logic       link_dev_drv
);
    // R10
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_host_drv && link_dev_drv));

    // R2
    act_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'b00)
        |=> (link_host_drv && link_bus[7:6] == 2'b00 && req_ready));

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op[1])
        |=> (!req_ready && link_host_drv));

    // R6
    turnaround_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_dev_drv) |-> $past(!link_host_drv && !link_dev_drv));

    // R7
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (req_ready && !link_dev_drv) ##1 !rd_valid);

endmodule

bind shared_pin_link slink_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .rd_valid      (rd_valid),
    .link_bus      (link_bus),
    .link_host_drv (link_host_drv),
    .link_dev_drv  (link_dev_drv)
);

// File: tb/shared_pin_link_bench.sv
`timescale 1ns/1ps
module shared_pin_link_bench;
    localparam int LAT = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [1:0]  req_bank = '0;
    logic [3:0]  req_row = '0;
    logic [7:0]  req_col = '0;
    logic [63:0] req_wdata = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [7:0]  link_bus;
    logic        link_host_drv;
    logic        link_dev_drv;

    int checks = 0;
    int fails  = 0;
    logic [3:0]  row_m [4];
    logic [63:0] mem_m [int];

    always #4 clk = ~clk;

    shared_pin_link #(.RD_LAT(LAT)) u_shared_pin_link (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] head(input logic [1:0] op, input int b, input int r);
        return {op, 2'(b), (op == 2'b00) ? 4'(r) : 4'h0};
    endfunction

    function automatic int key(input int b, input int r, input int c);
        return (b << 6) | (r << 2) | (c & 3);
    endfunction

    task automatic issue(input logic [1:0] op, input int b, input int r, input int c,
                         input logic [63:0] wd, input bit poke);
        logic [63:0] exp;
        int guard = 0;
        while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
        req_op = op; req_bank = 2'(b); req_row = 4'(r); req_col = 8'(c); req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(link_host_drv && !link_dev_drv && link_bus == head(op, b, r),
            op == 2'b00 ? "R2 head" : op == 2'b01 ? "R3 head" : "R4 head",
            {56'd0, link_bus}, {56'd0, head(op, b, r)});
        if (!op[1]) begin
            chk(req_ready, "R2 R3 ready kept", {63'd0, req_ready}, 64'd1);
            if (op == 2'b00) row_m[b] = 4'(r);
            @(negedge clk);
            chk(!link_host_drv, "R2 R3 single cycle", {63'd0, link_host_drv}, 64'd0);
            return;
        end
        chk(!req_ready, "R8 busy", {63'd0, req_ready}, 64'd0);
        @(negedge clk);
        chk(link_host_drv && link_bus == 8'(c), "R4 column", {56'd0, link_bus}, 64'(8'(c)));
        if (op == 2'b11) begin
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                chk(link_host_drv && !link_dev_drv && link_bus == wd[i*8 +: 8], "R5 beat",
                    {56'd0, link_bus}, {56'd0, wd[i*8 +: 8]});
            end
            @(negedge clk);
            chk(!link_host_drv && req_ready, "R5 R8 end", {62'd0, link_host_drv, req_ready}, 64'd1);
            mem_m[key(b, int'(row_m[b]), c)] = wd;
            return;
        end
        exp = mem_m[key(b, int'(row_m[b]), c)];
        if (poke) begin
            req_op = 2'b00; req_row = row_m[b] + 4'd1; req_valid = 1'b1;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!link_host_drv && !link_dev_drv, "R6 bubble", {62'd0, link_host_drv, link_dev_drv}, 64'd0);
        for (int i = 0; i < LAT; i++) begin
            @(negedge clk);
            chk(!link_host_drv && !link_dev_drv, "R6 latency idle", {62'd0, link_host_drv, link_dev_drv}, 64'd0);
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk(link_dev_drv && !link_host_drv && link_bus == exp[i*8 +: 8], "R9 R10 read beat",
                {56'd0, link_bus}, {56'd0, exp[i*8 +: 8]});
        end
        @(negedge clk);
        chk(rd_valid && req_ready && rd_data == exp, "R7 R9 assembled", rd_data, exp);
        @(negedge clk);
        chk(!rd_valid && !link_host_drv, "R7 R8 pulse end", {62'd0, rd_valid, link_host_drv}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int b, c, sel;
        logic [63:0] w;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) row_m[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rd_valid && !link_host_drv && !link_dev_drv, "R1 reset",
            {60'd0, req_ready, rd_valid, link_host_drv, link_dev_drv}, 64'h8);

        // Directed: row selection, ignored request while busy
        issue(2'b00, 0, 5, 0, '0, 0);
        issue(2'b11, 0, 0, 2, 64'h0123_4567_89AB_CDEF, 0);
        issue(2'b10, 0, 0, 2, '0, 1);
        issue(2'b10, 0, 0, 2, '0, 0);
        issue(2'b00, 0, 6, 0, '0, 0);
        issue(2'b11, 0, 0, 2, 64'hFEDC_BA98_7654_3210, 0);
        issue(2'b00, 0, 5, 0, '0, 0);
        issue(2'b10, 0, 0, 2, '0, 0);
        issue(2'b01, 1, 0, 0, '0, 0);

        // Back-to-back activates (R2)
        req_op = 2'b00; req_bank = 2'd2; req_row = 4'd9; req_valid = 1'b1;
        @(negedge clk);
        chk(link_host_drv && link_bus == head(2'b00, 2, 9) && req_ready, "R2 first of pair",
            {56'd0, link_bus}, {56'd0, head(2'b00, 2, 9)});
        req_bank = 2'd3; req_row = 4'd4;
        @(negedge clk);
        req_valid = 1'b0;
        chk(link_host_drv && link_bus == head(2'b00, 3, 4), "R2 second of pair",
            {56'd0, link_bus}, {56'd0, head(2'b00, 3, 4)});
        row_m[2] = 4'd9; row_m[3] = 4'd4;
        @(negedge clk);
        chk(!link_host_drv, "R2 pair end", {63'd0, link_host_drv}, 64'd0);

        // Random mix
        for (int n = 0; n < 200; n++) begin
            sel = $urandom_range(0, 3);
            b = $urandom_range(0, 3);
            c = $urandom_range(0, 255);
            w = {$urandom, $urandom};
            case (sel)
                0: issue(2'b00, b, $urandom_range(0, 15), 0, '0, 0);
                1: issue(2'b01, b, 0, 0, '0, 0);
                2: if (mem_m.exists(key(b, int'(row_m[b]), c))) issue(2'b10, b, 0, c, '0, n[0]);
                   else issue(2'b11, b, 0, c, w, 0);
                default: issue(2'b11, b, 0, c, w, 0);
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule